// File: doc/BRIEF.md
# DDR2 Burst Latency and Interrupt Checker

This block watches the command stream that a DDR2-style memory controller or device model sends, and works out when each read or write burst occupies the data bus. From the programmed additive latency and CAS latency it derives the read latency (their sum) and the write latency (one cycle less). It opens a read or write data window at that distance from the command and keeps it open for half the burst length in clock cycles, because two beats move per clock. One cycle before every window it raises a preamble indication for the matching direction.

The block also polices the command stream. A new column command whose data would begin before the previous burst has finished counts as an interruption. With 4-beat bursts every interruption is illegal. With 8-beat bursts a read may cut short a read and a write may cut short a write, and the new burst then takes over the bus at its own first beat. The block flags a burst-stop opcode, which this memory type does not support. It also flags a precharge that comes while write data is still pending, or before the write-recovery time has run out after the last write beat. All violation outputs are sticky until a clear pulse or a reset.

Top module: `ddr_burst_guard`

## Requirements
- R1: `cmd_op` value 0 means idle. A READ (`cmd_op` = 1) in cycle n drives `rd_window` high in cycles n+AL+CL through n+AL+CL+L-1, where L is 2 when `cfg_bl8` = 0 (4 beats) and 4 when `cfg_bl8` = 1 (8 beats). CL is programmed from 3 upward.
- R2: A WRITE (`cmd_op` = 2) in cycle n drives `wr_window` high from cycle n+AL+CL-1 for L cycles. It is low again in the cycle after the last beat, so any data offered after the burst is not accepted.
- R3: `rd_preamble` (or `wr_preamble`) is high in exactly the cycle before each read (or write) window begins.
- R4: A burst overlaps another when its first window cycle is at or before the last window cycle of the most recently scheduled burst. With 4-beat bursts, any READ or WRITE that overlaps sets `err_interrupt` in the next cycle. Bursts that follow each other with no gap do not set it.
- R5: With 8-beat bursts, a READ overlapping a READ, or a WRITE overlapping a WRITE, leaves `err_interrupt` clear. The older window ends where the newer one starts, so one window runs without a break to the end of the newer burst. `rd_window` and `wr_window` are never high together.
- R6: With 8-beat bursts, a READ overlapping a WRITE, or a WRITE overlapping a READ, sets `err_interrupt` in the next cycle.
- R7: The burst-stop opcode (`cmd_op` = 4) sets `err_burst_stop` in the next cycle.
- R8: Let e be the last write window cycle and WR be `cfg_wr`. A PRECHARGE (`cmd_op` = 3) in cycle p sets `err_recovery` in the next cycle if p <= e+WR, which includes any time a write is still scheduled or in progress. A precharge at p >= e+WR+1 leaves it clear.
- R9: The three error outputs stay set until `clr_flags` is sampled high, which clears them in the next cycle unless a new violation occurs in that same cycle. After `rst`, every output is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr_flags | input | 1 | Clears the sticky error outputs |
| cmd_op | input | 3 | Command: 0 idle, 1 read, 2 write, 3 precharge, 4 burst stop |
| cfg_bl8 | input | 1 | 1 selects 8-beat bursts, 0 selects 4-beat bursts |
| cfg_al | input | AL_W | Additive latency in cycles |
| cfg_cl | input | CL_W | CAS latency in cycles |
| cfg_wr | input | WR_W | Write-recovery time in cycles |
| rd_preamble | output | 1 | Read window starts next cycle |
| wr_preamble | output | 1 | Write window starts next cycle |
| rd_window | output | 1 | Read data is on the bus this cycle |
| wr_window | output | 1 | Write data is accepted this cycle |
| err_interrupt | output | 1 | Sticky: illegal burst interruption |
| err_burst_stop | output | 1 | Sticky: unsupported burst-stop opcode |
| err_recovery | output | 1 | Sticky: precharge too soon after a write |

## Verification
A marker that lands in the wrong slot of the latency line shows up at the ports as a window or preamble one or more cycles early or late. The bench compares every cycle with a schedule it builds itself, so the slip is reported in the first wrong cycle. A wrong end-of-burst tracker does not show in the windows at all. It shows as `err_interrupt` or `err_recovery` being set or left clear on the command that probes the boundary, and that flag is visible one cycle after the command. The random pairs and random precharge distances therefore sweep the gap across both sides of each boundary.

// File: rtl/ddr_guard_pkg.sv
package ddr_guard_pkg;

    typedef enum logic [2:0] {
        OP_IDLE       = 3'd0,
        OP_READ       = 3'd1,
        OP_WRITE      = 3'd2,
        OP_PRECHARGE  = 3'd3,
        OP_BURST_STOP = 3'd4
    } cmd_op_e;

    // one pending window start in the latency line
    typedef struct packed {
        logic valid;
        logic is_wr;
    } slot_t;

    // sticky violation set
    typedef struct packed {
        logic intr;
        logic bstop;
        logic recov;
    } viol_t;

    // cycles from the registered command to the first data cycle
    function automatic int unsigned burst_latency(input logic is_wr,
                                                  input int unsigned al,
                                                  input int unsigned cl);
        int unsigned lat;
        lat = al + cl;
        if (is_wr && lat != 0) lat = lat - 1;
        if (lat < 2) lat = 2;
        return lat;
    endfunction

    // two beats per clock
    function automatic int unsigned window_cycles(input logic bl8);
        return bl8 ? 4 : 2;
    endfunction

endpackage

// File: rtl/ddr_latency_line.sv
module ddr_latency_line
    import ddr_guard_pkg::*;
#(
    parameter int DEPTH = 14,
    parameter int LAT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ins_en,
    input  logic             ins_wr,
    input  logic [LAT_W-1:0] ins_lat,
    output slot_t            head
);
    // bit k set: a window starts k+1 cycles from now
    logic [DEPTH-1:0] vld_q, wr_q;
    logic [DEPTH-1:0] hit;

    generate
        for (genvar k = 0; k < DEPTH; k++) begin : g_slot
            assign hit[k] = ins_en && (ins_lat == LAT_W'(k + 2));
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= '0;
            wr_q  <= '0;
        end else begin
            vld_q <= (vld_q >> 1) | hit;
            wr_q  <= ((wr_q >> 1) & ~hit) | (hit & {DEPTH{ins_wr}});
        end
    end

    assign head = '{valid: vld_q[0], is_wr: wr_q[0]};

endmodule

// File: rtl/ddr_burst_window.sv
module ddr_burst_window
    import ddr_guard_pkg::*;
#(
    parameter int LEN_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  slot_t            start,
    input  logic [LEN_W-1:0] len,
    output logic             rd_active,
    output logic             wr_active
);
    logic [LEN_W-1:0] left_q;
    logic             wr_q;

    // a new start reloads the count, which cuts the older burst short
    always_ff @(posedge clk) begin
        if (rst) begin
            left_q <= '0;
            wr_q   <= 1'b0;
        end else if (start.valid) begin
            left_q <= len;
            wr_q   <= start.is_wr;
        end else if (left_q != '0) begin
            left_q <= left_q - 1'b1;
        end
    end

    assign rd_active = (left_q != '0) && !wr_q;
    assign wr_active = (left_q != '0) &&  wr_q;

endmodule

// File: rtl/ddr_rule_check.sv
module ddr_rule_check
    import ddr_guard_pkg::*;
#(
    parameter int LAT_W = 4,
    parameter int LEN_W = 3,
    parameter int WR_W  = 3,
    parameter int REM_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic [2:0]       op,
    input  logic             bl8,
    input  logic [LAT_W-1:0] cmd_lat,
    input  logic [LEN_W-1:0] cmd_len,
    input  logic [WR_W-1:0]  wr_time,
    output viol_t            flags
);
    logic is_rd, is_wr, is_col, is_pre, is_bs;
    assign is_rd  = (op == OP_READ);
    assign is_wr  = (op == OP_WRITE);
    assign is_col = is_rd || is_wr;
    assign is_pre = (op == OP_PRECHARGE);
    assign is_bs  = (op == OP_BURST_STOP);

    // latest burst: cycles until its last window cycle
    logic             any_busy_q, last_wr_q;
    logic [REM_W-1:0] any_rem_q;
    // latest write burst and the recovery count after it
    logic             wr_busy_q;
    logic [REM_W-1:0] wr_rem_q;
    logic [WR_W-1:0]  rec_q;
    viol_t            flags_q, hit;

    logic [REM_W-1:0] new_end;
    logic             overlap;
    assign new_end = REM_W'(cmd_lat) + REM_W'(cmd_len) - REM_W'(2);
    assign overlap = any_busy_q && (any_rem_q >= REM_W'(cmd_lat));

    always_comb begin
        hit       = '0;
        hit.intr  = is_col && overlap && (!bl8 || (last_wr_q != is_wr));
        hit.bstop = is_bs;
        hit.recov = is_pre && (wr_busy_q || rec_q != '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q    <= '0;
            any_busy_q <= 1'b0;
            any_rem_q  <= '0;
            last_wr_q  <= 1'b0;
            wr_busy_q  <= 1'b0;
            wr_rem_q   <= '0;
            rec_q      <= '0;
        end else begin
            flags_q <= (clr ? viol_t'('0) : flags_q) | hit;

            if (is_col) begin
                any_busy_q <= 1'b1;
                any_rem_q  <= new_end;
                last_wr_q  <= is_wr;
            end else if (any_busy_q) begin
                if (any_rem_q == '0) any_busy_q <= 1'b0;
                else                 any_rem_q  <= any_rem_q - 1'b1;
            end

            if (is_wr) begin
                wr_busy_q <= 1'b1;
                wr_rem_q  <= new_end;
            end else if (wr_busy_q) begin
                if (wr_rem_q == '0) wr_busy_q <= 1'b0;
                else                wr_rem_q  <= wr_rem_q - 1'b1;
            end

            if (wr_busy_q && wr_rem_q == '0 && !is_wr) rec_q <= wr_time;
            else if (rec_q != '0)                     rec_q <= rec_q - 1'b1;
        end
    end

    assign flags = flags_q;

endmodule

// File: rtl/ddr_burst_guard.sv
module ddr_burst_guard
    import ddr_guard_pkg::*;
#(
    parameter int AL_W = 3,
    parameter int CL_W = 3,
    parameter int WR_W = 3
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            clr_flags,
    input  logic [2:0]      cmd_op,
    input  logic            cfg_bl8,
    input  logic [AL_W-1:0] cfg_al,
    input  logic [CL_W-1:0] cfg_cl,
    input  logic [WR_W-1:0] cfg_wr,
    output logic            rd_preamble,
    output logic            wr_preamble,
    output logic            rd_window,
    output logic            wr_window,
    output logic            err_interrupt,
    output logic            err_burst_stop,
    output logic            err_recovery
);
    localparam int MAX_LAT = (1 << AL_W) - 1 + (1 << CL_W) - 1;
    localparam int LAT_W   = $clog2(MAX_LAT + 1);
    localparam int LEN_W   = 3;
    localparam int REM_W   = $clog2(MAX_LAT + 6);

    logic             is_wr_cmd, is_col_cmd;
    logic [LAT_W-1:0] cmd_lat;
    logic [LEN_W-1:0] cmd_len;
    slot_t            head;
    viol_t            flags;

    assign is_wr_cmd  = (cmd_op == OP_WRITE);
    assign is_col_cmd = (cmd_op == OP_READ) || is_wr_cmd;
    assign cmd_lat    = LAT_W'(burst_latency(is_wr_cmd, 32'(cfg_al), 32'(cfg_cl)));
    assign cmd_len    = LEN_W'(window_cycles(cfg_bl8));

    ddr_latency_line #(.DEPTH(MAX_LAT), .LAT_W(LAT_W)) u_line (
        .clk     (clk),
        .rst     (rst),
        .ins_en  (is_col_cmd),
        .ins_wr  (is_wr_cmd),
        .ins_lat (cmd_lat),
        .head    (head)
    );

    ddr_burst_window #(.LEN_W(LEN_W)) u_window (
        .clk       (clk),
        .rst       (rst),
        .start     (head),
        .len       (cmd_len),
        .rd_active (rd_window),
        .wr_active (wr_window)
    );

    ddr_rule_check #(.LAT_W(LAT_W), .LEN_W(LEN_W), .WR_W(WR_W), .REM_W(REM_W)) u_rules (
        .clk     (clk),
        .rst     (rst),
        .clr     (clr_flags),
        .op      (cmd_op),
        .bl8     (cfg_bl8),
        .cmd_lat (cmd_lat),
        .cmd_len (cmd_len),
        .wr_time (cfg_wr),
        .flags   (flags)
    );

    assign rd_preamble    = head.valid && !head.is_wr;
    assign wr_preamble    = head.valid &&  head.is_wr;
    assign err_interrupt  = flags.intr;
    assign err_burst_stop = flags.bstop;
    assign err_recovery   = flags.recov;

endmodule

// File: rtl/ddr_burst_guard_checker.sv
module ddr_burst_guard_checker #(
    parameter int WR_W = 3
) (
    input logic            clk,
    input logic            rst,
    input logic            clr_flags,
    input logic [2:0]      cmd_op,
    input logic [WR_W-1:0] cfg_wr,
    input logic            rd_preamble,
    input logic            wr_preamble,
    input logic            rd_window,
    input logic            wr_window,
    input logic            err_interrupt,
    input logic            err_burst_stop,
    input logic            err_recovery
);
    assert_windows_exclusive_R5: assert property (@(posedge clk) disable iff (rst)
        !(rd_window && wr_window));

    assert_rd_preamble_leads_R3: assert property (@(posedge clk) disable iff (rst)
        rd_preamble |=> rd_window);

    assert_wr_preamble_leads_R3: assert property (@(posedge clk) disable iff (rst)
        wr_preamble |=> wr_window);

    assert_burst_stop_flagged_R7: assert property (@(posedge clk) disable iff (rst)
        (cmd_op == 3'd4) |=> err_burst_stop);

    assert_early_precharge_R8: assert property (@(posedge clk) disable iff (rst)
        ($fell(wr_window) && cmd_op == 3'd3 && cfg_wr != '0) |=> err_recovery);

    assert_interrupt_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        (err_interrupt && !clr_flags) |=> err_interrupt);

    assert_recovery_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        (err_recovery && !clr_flags) |=> err_recovery);

    assert_clear_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        (clr_flags && cmd_op == 3'd0) |=> !(err_interrupt || err_burst_stop || err_recovery));

endmodule

bind ddr_burst_guard ddr_burst_guard_checker #(.WR_W(WR_W)) u_checker (
    .clk            (clk),
    .rst            (rst),
    .clr_flags      (clr_flags),
    .cmd_op         (cmd_op),
    .cfg_wr         (cfg_wr),
    .rd_preamble    (rd_preamble),
    .wr_preamble    (wr_preamble),
    .rd_window      (rd_window),
    .wr_window      (wr_window),
    .err_interrupt  (err_interrupt),
    .err_burst_stop (err_burst_stop),
    .err_recovery   (err_recovery)
);

// File: tb/ddr_burst_guard_test.sv
module ddr_burst_guard_test;

    localparam int CLK_PERIOD = 10;
    localparam int NCYC       = 8192;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       clr_flags = 1'b0;
    logic [2:0] cmd_op = 3'd0;
    logic       cfg_bl8 = 1'b0;
    logic [2:0] cfg_al = 3'd0;
    logic [2:0] cfg_cl = 3'd3;
    logic [2:0] cfg_wr = 3'd0;
    logic rd_preamble, wr_preamble, rd_window, wr_window;
    logic err_interrupt, err_burst_stop, err_recovery;

    int cyc = 0;
    int vectors = 0;
    int miscompares = 0;
    bit chk_win = 1'b0;
    bit done = 1'b0;
    bit exp_rd  [NCYC];
    bit exp_wr  [NCYC];
    bit exp_rdp [NCYC];
    bit exp_wrp [NCYC];

    ddr_burst_guard uut (
        .clk(clk), .rst(rst), .clr_flags(clr_flags), .cmd_op(cmd_op),
        .cfg_bl8(cfg_bl8), .cfg_al(cfg_al), .cfg_cl(cfg_cl), .cfg_wr(cfg_wr),
        .rd_preamble(rd_preamble), .wr_preamble(wr_preamble),
        .rd_window(rd_window), .wr_window(wr_window),
        .err_interrupt(err_interrupt), .err_burst_stop(err_burst_stop),
        .err_recovery(err_recovery)
    );

    initial forever #(CLK_PERIOD / 2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // expected-value functions, from the requirements
    function automatic int exp_lat(bit wr, int al, int cl);
        return al + cl - (wr ? 1 : 0);
    endfunction

    function automatic int exp_len(bit bl8);
        return bl8 ? 4 : 2;
    endfunction

    function automatic bit exp_overlap(int n1, int lat1, int len, int n2, int lat2);
        return (n2 + lat2) <= (n1 + lat1 + len - 1);
    endfunction

    task automatic chk(input string req, input string what, input int act, input int expv);
        vectors++;
        if (act != expv) begin
            miscompares++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, expv);
        end
    endtask

    // cycle-by-cycle window and preamble comparison (R1, R2, R3)
    always @(negedge clk) begin
        if (!rst && chk_win && cyc < NCYC) begin
            chk("R1", $sformatf("rd_window cycle %0d", cyc), int'(rd_window), int'(exp_rd[cyc]));
            chk("R2", $sformatf("wr_window cycle %0d", cyc), int'(wr_window), int'(exp_wr[cyc]));
            chk("R3", $sformatf("rd_preamble cycle %0d", cyc), int'(rd_preamble), int'(exp_rdp[cyc]));
            chk("R3", $sformatf("wr_preamble cycle %0d", cyc), int'(wr_preamble), int'(exp_wrp[cyc]));
        end
    end

    task automatic idle(input int k);
        for (int i = 0; i < k; i++) @(negedge clk);
    endtask

    task automatic wait_until(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        idle(2);
        rst = 1'b0;
    endtask

    task automatic pulse_clear();
        clr_flags = 1'b1;
        @(negedge clk);
        clr_flags = 1'b0;
    endtask

    // drive one command for one cycle and record its expected window
    task automatic issue(input logic [2:0] op);
        int n, lat, len, s;
        bit wr;
        n = cyc;
        wr = (op == 3'd2);
        cmd_op = op;
        if (op == 3'd1 || op == 3'd2) begin
            lat = exp_lat(wr, int'(cfg_al), int'(cfg_cl));
            len = exp_len(cfg_bl8);
            s = n + lat;
            if (s + len < NCYC) begin
                if (wr) exp_wrp[s - 1] = 1'b1;
                else    exp_rdp[s - 1] = 1'b1;
                for (int i = 0; i < len; i++) begin
                    if (wr) exp_wr[s + i] = 1'b1;
                    else    exp_rd[s + i] = 1'b1;
                end
            end
        end
        @(negedge clk);
        cmd_op = 3'd0;
    endtask

    task automatic run_pair(input bit bl8, input int al, input int cl,
                            input bit w1, input bit w2, input int gap, input string req);
        int n1, n2, lat1, lat2, len;
        bit exp_flag;
        cfg_bl8 = bl8;
        cfg_al = 3'(al);
        cfg_cl = 3'(cl);
        pulse_clear();
        len  = exp_len(bl8);
        lat1 = exp_lat(w1, al, cl);
        lat2 = exp_lat(w2, al, cl);
        n1 = cyc;
        n2 = n1 + gap;
        exp_flag = exp_overlap(n1, lat1, len, n2, lat2) && (!bl8 || w1 != w2);
        issue(w1 ? 3'd2 : 3'd1);
        idle(gap - 1);
        if (exp_flag && w1 != w2) chk_win = 1'b0;
        issue(w2 ? 3'd2 : 3'd1);
        idle(20);
        chk(req, $sformatf("err_interrupt bl8=%0d w1=%0d w2=%0d gap=%0d", bl8, w1, w2, gap),
            int'(err_interrupt), int'(exp_flag));
        if (!chk_win) begin
            do_reset();
            chk_win = 1'b1;
        end
    endtask

    // write, then precharge at (last write cycle + extra)
    task automatic run_recovery(input bit bl8, input int al, input int cl,
                                input int wr, input int extra);
        int n, e;
        cfg_bl8 = bl8;
        cfg_al = 3'(al);
        cfg_cl = 3'(cl);
        cfg_wr = 3'(wr);
        pulse_clear();
        n = cyc;
        e = n + exp_lat(1'b1, al, cl) + exp_len(bl8) - 1;
        issue(3'd2);
        wait_until(e + extra);
        issue(3'd3);
        chk("R8", $sformatf("err_recovery wr=%0d extra=%0d", wr, extra),
            int'(err_recovery), (extra <= wr) ? 1 : 0);
        idle(15);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        do_reset();
        @(negedge clk);
        // R9: reset state
        chk("R9", "rd_preamble after reset", int'(rd_preamble), 0);
        chk("R9", "wr_preamble after reset", int'(wr_preamble), 0);
        chk("R9", "rd_window after reset", int'(rd_window), 0);
        chk("R9", "wr_window after reset", int'(wr_window), 0);
        chk("R9", "err_interrupt after reset", int'(err_interrupt), 0);
        chk("R9", "err_burst_stop after reset", int'(err_burst_stop), 0);
        chk("R9", "err_recovery after reset", int'(err_recovery), 0);
        chk_win = 1'b1;

        // R1: single read, 4 beats, smallest latency
        cfg_bl8 = 1'b0; cfg_al = 3'd0; cfg_cl = 3'd3;
        issue(3'd1);
        idle(12);
        // R2: single write, 8 beats, with additive latency
        cfg_bl8 = 1'b1; cfg_al = 3'd2; cfg_cl = 3'd4;
        issue(3'd2);
        idle(16);

        // R4: back-to-back 4-beat reads (no gap) are legal, one cycle closer is not
        run_pair(1'b0, 0, 3, 1'b0, 1'b0, 2, "R4");
        run_pair(1'b0, 0, 3, 1'b0, 1'b0, 1, "R4");
        run_pair(1'b0, 1, 4, 1'b0, 1'b1, 1, "R4");
        // R5: same-type interruption with 8 beats
        run_pair(1'b1, 1, 3, 1'b0, 1'b0, 2, "R5");
        run_pair(1'b1, 0, 5, 1'b1, 1'b1, 3, "R5");
        // R6: mixed interruption with 8 beats
        run_pair(1'b1, 0, 4, 1'b0, 1'b1, 1, "R6");
        run_pair(1'b1, 2, 3, 1'b1, 1'b0, 2, "R6");

        // R9: clear drops a set flag
        pulse_clear();
        chk("R9", "err_interrupt after clear", int'(err_interrupt), 0);

        // R7: burst stop flagged, other flags untouched
        issue(3'd4);
        chk("R7", "err_burst_stop after burst stop", int'(err_burst_stop), 1);
        chk("R7", "err_interrupt after burst stop", int'(err_interrupt), 0);
        chk("R7", "err_recovery after burst stop", int'(err_recovery), 0);
        idle(3);
        chk("R9", "err_burst_stop held", int'(err_burst_stop), 1);
        // R9: violation in the clear cycle wins
        clr_flags = 1'b1;
        issue(3'd4);
        clr_flags = 1'b0;
        chk("R9", "err_burst_stop set with clear", int'(err_burst_stop), 1);
        pulse_clear();
        chk("R9", "err_burst_stop cleared", int'(err_burst_stop), 0);

        // R8: recovery boundary and precharge during the write
        run_recovery(1'b0, 0, 3, 3, 3);
        run_recovery(1'b0, 0, 3, 3, 4);
        run_recovery(1'b1, 1, 3, 2, -1);
        run_recovery(1'b1, 0, 4, 0, 1);

        // random interruption pairs
        for (int k = 0; k < 60; k++) begin
            bit bl8, w1, w2;
            int al, cl, gap;
            string req;
            bl8 = 1'($urandom % 2);
            w1  = 1'($urandom % 2);
            w2  = 1'($urandom % 2);
            al  = int'($urandom % 4);
            cl  = 3 + int'($urandom % 4);
            gap = 1 + int'($urandom % 6);
            if (!bl8)          req = "R4";
            else if (w1 == w2) req = "R5";
            else               req = "R6";
            run_pair(bl8, al, cl, w1, w2, gap, req);
        end

        // random recovery distances
        for (int k = 0; k < 40; k++) begin
            run_recovery(1'($urandom % 2), int'($urandom % 4), 3 + int'($urandom % 4),
                         int'($urandom % 8), int'($urandom % 10) - 1);
        end

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: got 0 expected 1 (run completion)");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule